// File: doc/BRIEF.md
# Exact-Product Sum-of-Products Front End

This block forms a running sum of floating-point products with no intermediate rounding. On every cycle on which `in_valid_i` is high it multiplies two operands and keeps the whole significand product: 2 + 2·FRAC_W bits, with no normalisation and no rounding. It turns the sign and the unbiased exponent sum into a shift amount. It places the product in a wide two's-complement fixed-point register, subtracting it when the product is negative. The register's least significant bit has weight `ACC_LSB` and its sign bit has weight `ACC_MSB`. The raw register value leaves the block as it is; turning it back into floating point is left to other logic.

Products are added one per cycle, back to back, through a fixed four-stage pipeline. A product flagged with `first_i` starts a new sum: it is loaded instead of added, and both sticky flags restart from that product's own conditions. The product-size flag reports products whose leading bit lies above `PROD_MSB_MAX`, the largest weight the aligner can place. The accumulator flag reports any signed overflow of the register.

Top module: `xprod_sop`

## Requirements
- R1: An operand is {sign at bit OP_W-1, exponent field of EXP_W bits below it with bias 2^(EXP_W-1)-1, fraction of FRAC_W bits at the bottom}, with value (-1)^s·(1.f)·2^(field-bias). Product bit i of the exact (FRAC_W+1)×(FRAC_W+1)-bit significand product has weight ea+eb-2·FRAC_W+i, where ea and eb are the unbiased exponents.
- R2: A product sampled with `in_valid_i` high at one rising edge is included in `acc_o`, and `out_valid_o` is high, after the fourth rising edge counted from the sampling edge; `out_valid_o` is high for exactly one cycle per accepted product.
- R3: An operand whose exponent field is 0 makes the product zero: the product changes neither `acc_o` nor `prod_big_o`.
- R4: Product bits of weight ACC_LSB or above are accumulated exactly. Bits below ACC_LSB are dropped from the magnitude before the sign is applied, so the magnitude is truncated toward zero.
- R5: The product sign is the XOR of the operand signs; a negative product is subtracted from `acc_o`.
- R6: A non-zero product whose leading bit weight (ea+eb+1) exceeds PROD_MSB_MAX is not added, and it sets the sticky `prod_big_o`.
- R7: A sum outside the signed ACC_W-bit range wraps modulo 2^ACC_W in `acc_o` and sets the sticky `acc_ovf_o`.
- R8: A product with `first_i` high replaces the accumulator contents instead of being added. `prod_big_o` then shows only that product's own size check, and `acc_ovf_o` becomes 0.
- R9: While `in_valid_i` is low, no product enters: `acc_o` and both flags keep their values and `out_valid_o` stays low.
- R10: A synchronous active-high reset clears `acc_o`, `prod_big_o`, `acc_ovf_o` and `out_valid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| in_valid_i | input | 1 | Operand pair present |
| first_i | input | 1 | This product starts a new sum |
| opa_i | input | OP_W | First operand (sign, exponent, fraction) |
| opb_i | input | OP_W | Second operand (sign, exponent, fraction) |
| acc_o | output | ACC_W | Raw two's-complement accumulator, LSB weight ACC_LSB |
| prod_big_o | output | 1 | Sticky: a product was too large for the aligner |
| acc_ovf_o | output | 1 | Sticky: the accumulator overflowed |
| out_valid_o | output | 1 | The accumulator has just taken a product |

## Verification
Each accepted product shows up in `acc_o`, the two sticky flags and `out_valid_o` after the fourth rising edge from the edge that sampled it. Nothing in the result path is combinational from the inputs. When it drives a product, the bench stores the expected accumulator and flag values together with the cycle number at which they fall due. It compares them on the falling edge of that cycle. On every other cycle it checks that `out_valid_o` is low and that the accumulator and flags have not moved. Back-to-back products, idle gaps and restarts are mixed, so a pipeline that is off by one cycle, or that drops or duplicates a product, shows up as a mismatch at a due cycle.

// File: rtl/xsop_pkg.sv
package xsop_pkg;

    // Limit a signed shift request to the range an aligner can apply.
    function automatic int clamp_shift(input int t, input int lim);
        if (t < 0)
            return 0;
        if (t > lim)
            return lim;
        return t;
    endfunction

    // Signed overflow of a two's-complement add from the three sign bits.
    function automatic logic add_overflow(input logic a_msb, input logic b_msb,
                                          input logic s_msb);
        return (a_msb == b_msb) && (s_msb != a_msb);
    endfunction

endpackage

// File: rtl/xsop_mul.sv
// Two pipeline stages: operand decode, then exact significand product and
// the aligner shift amount. No normalisation, no rounding.
module xsop_mul #(
    parameter int EXP_W        = 6,
    parameter int FRAC_W       = 7,
    parameter int PROD_MSB_MAX = 12,
    parameter int AL_W         = 29,
    localparam int OP_W  = 1 + EXP_W + FRAC_W,
    localparam int SIG_W = FRAC_W + 1,
    localparam int PW    = 2 * SIG_W,
    localparam int LIM   = PW + AL_W,
    localparam int SH_W  = $clog2(LIM + 1)
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic            in_valid_i,
    input  logic            first_i,
    input  logic [OP_W-1:0] opa_i,
    input  logic [OP_W-1:0] opb_i,
    output logic            vld_o,
    output logic            first_o,
    output logic            sgn_o,
    output logic            big_o,
    output logic [PW-1:0]   prod_o,
    output logic [SH_W-1:0] shamt_o
);
    import xsop_pkg::*;

    localparam int BIAS = (1 << (EXP_W - 1)) - 1;
    localparam int ES_W = EXP_W + 2;

    typedef struct packed {
        logic                   vld;
        logic                   first;
        logic                   sgn;
        logic                   zero;
        logic signed [ES_W-1:0] esum;
        logic [SIG_W-1:0]       siga;
        logic [SIG_W-1:0]       sigb;
    } dec_t;

    typedef struct packed {
        logic            vld;
        logic            first;
        logic            sgn;
        logic            big;
        logic [PW-1:0]   prod;
        logic [SH_W-1:0] shamt;
    } mul_t;

    typedef struct packed {
        dec_t dec;
        mul_t mul;
    } state_t;

    state_t st_d, st_q;

    logic [EXP_W-1:0] ea, eb;
    int               esum_i;
    int               t_full;

    assign ea = opa_i[OP_W-2 -: EXP_W];
    assign eb = opb_i[OP_W-2 -: EXP_W];

    always_comb begin
        st_d = st_q;

        // stage 1: decode
        esum_i          = int'(ea) + int'(eb) - 2 * BIAS;
        st_d.dec.vld    = in_valid_i;
        st_d.dec.first  = first_i;
        st_d.dec.sgn    = opa_i[OP_W-1] ^ opb_i[OP_W-1];
        st_d.dec.zero   = (ea == '0) || (eb == '0);
        st_d.dec.esum   = esum_i[ES_W-1:0];
        st_d.dec.siga   = {1'b1, opa_i[FRAC_W-1:0]};
        st_d.dec.sigb   = {1'b1, opb_i[FRAC_W-1:0]};

        // stage 2: exact product and shift amount
        t_full          = PROD_MSB_MAX - 1 - int'(st_q.dec.esum);
        st_d.mul.vld    = st_q.dec.vld;
        st_d.mul.first  = st_q.dec.first;
        st_d.mul.sgn    = st_q.dec.sgn;
        st_d.mul.big    = !st_q.dec.zero && (t_full < 0);
        st_d.mul.prod   = st_q.dec.zero ? '0 : (PW'(st_q.dec.siga) * PW'(st_q.dec.sigb));
        st_d.mul.shamt  = SH_W'(clamp_shift(t_full, LIM));
    end

    always_ff @(posedge clk_i) begin
        if (rst_i)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign vld_o   = st_q.mul.vld;
    assign first_o = st_q.mul.first;
    assign sgn_o   = st_q.mul.sgn;
    assign big_o   = st_q.mul.big;
    assign prod_o  = st_q.mul.prod;
    assign shamt_o = st_q.mul.shamt;

endmodule

// File: rtl/xsop_align.sv
// Third stage: places the double-width product at its weight inside the
// aligner window; bits under the accumulator LSB fall off the bottom.
module xsop_align #(
    parameter int PW   = 16,
    parameter int AL_W = 29,
    localparam int LIM  = PW + AL_W,
    localparam int SH_W = $clog2(LIM + 1)
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic            vld_i,
    input  logic            first_i,
    input  logic            sgn_i,
    input  logic            big_i,
    input  logic [PW-1:0]   prod_i,
    input  logic [SH_W-1:0] shamt_i,
    output logic            vld_o,
    output logic            first_o,
    output logic            neg_o,
    output logic            big_o,
    output logic [AL_W-1:0] mag_o
);

    typedef struct packed {
        logic            vld;
        logic            first;
        logic            neg;
        logic            big;
        logic [AL_W-1:0] mag;
    } al_t;

    al_t st_d, st_q;

    logic [LIM-1:0] wide;

    always_comb begin
        wide        = {prod_i, {AL_W{1'b0}}} >> shamt_i;
        st_d.vld    = vld_i;
        st_d.first  = first_i;
        st_d.big    = big_i;
        st_d.neg    = sgn_i && !big_i;
        st_d.mag    = big_i ? '0 : wide[LIM-1 -: AL_W];
    end

    always_ff @(posedge clk_i) begin
        if (rst_i)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign vld_o   = st_q.vld;
    assign first_o = st_q.first;
    assign neg_o   = st_q.neg;
    assign big_o   = st_q.big;
    assign mag_o   = st_q.mag;

endmodule

// File: rtl/xsop_accum.sv
// Fourth stage: the only loop. A negative term enters as its bitwise
// complement plus a carry-in, so the loop holds just one adder.
module xsop_accum #(
    parameter int AL_W  = 29,
    parameter int ACC_W = 37
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             vld_i,
    input  logic             first_i,
    input  logic             neg_i,
    input  logic             big_i,
    input  logic [AL_W-1:0]  mag_i,
    output logic [ACC_W-1:0] acc_o,
    output logic             prod_big_o,
    output logic             acc_ovf_o,
    output logic             vld_o
);
    import xsop_pkg::*;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic             pbig;
        logic             ovf;
        logic             vld;
    } acc_t;

    acc_t st_d, st_q;

    logic [ACC_W-1:0] ext;
    logic [ACC_W-1:0] addend;
    logic [ACC_W-1:0] base;
    logic [ACC_W-1:0] sum;
    logic             ovf_now;

    always_comb begin
        ext     = ACC_W'(mag_i);
        addend  = neg_i ? ~ext : ext;
        base    = first_i ? '0 : st_q.acc;
        sum     = base + addend + ACC_W'(neg_i);
        ovf_now = add_overflow(base[ACC_W-1], addend[ACC_W-1], sum[ACC_W-1]);

        st_d     = st_q;
        st_d.vld = vld_i;
        if (vld_i) begin
            st_d.acc = sum;
            if (first_i) begin
                st_d.pbig = big_i;
                st_d.ovf  = ovf_now;
            end else begin
                st_d.pbig = st_q.pbig | big_i;
                st_d.ovf  = st_q.ovf | ovf_now;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign acc_o      = st_q.acc;
    assign prod_big_o = st_q.pbig;
    assign acc_ovf_o  = st_q.ovf;
    assign vld_o      = st_q.vld;

endmodule

// File: rtl/xprod_sop.sv
module xprod_sop #(
    parameter int EXP_W        = 6,
    parameter int FRAC_W       = 7,
    parameter int ACC_LSB      = -16,
    parameter int ACC_MSB      = 20,
    parameter int PROD_MSB_MAX = 12,
    localparam int OP_W  = 1 + EXP_W + FRAC_W,
    localparam int ACC_W = ACC_MSB - ACC_LSB + 1
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             in_valid_i,
    input  logic             first_i,
    input  logic [OP_W-1:0]  opa_i,
    input  logic [OP_W-1:0]  opb_i,
    output logic [ACC_W-1:0] acc_o,
    output logic             prod_big_o,
    output logic             acc_ovf_o,
    output logic             out_valid_o
);

    localparam int PW   = 2 * (FRAC_W + 1);
    localparam int AL_W = PROD_MSB_MAX - ACC_LSB + 1;
    localparam int SH_W = $clog2(PW + AL_W + 1);

    logic            m_vld, m_first, m_sgn, m_big;
    logic [PW-1:0]   m_prod;
    logic [SH_W-1:0] m_shamt;

    logic            a_vld, a_first, a_neg, a_big;
    logic [AL_W-1:0] a_mag;

    xsop_mul #(
        .EXP_W       (EXP_W),
        .FRAC_W      (FRAC_W),
        .PROD_MSB_MAX(PROD_MSB_MAX),
        .AL_W        (AL_W)
    ) u_mul (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .in_valid_i (in_valid_i),
        .first_i    (first_i),
        .opa_i      (opa_i),
        .opb_i      (opb_i),
        .vld_o      (m_vld),
        .first_o    (m_first),
        .sgn_o      (m_sgn),
        .big_o      (m_big),
        .prod_o     (m_prod),
        .shamt_o    (m_shamt)
    );

    xsop_align #(
        .PW  (PW),
        .AL_W(AL_W)
    ) u_align (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .vld_i   (m_vld),
        .first_i (m_first),
        .sgn_i   (m_sgn),
        .big_i   (m_big),
        .prod_i  (m_prod),
        .shamt_i (m_shamt),
        .vld_o   (a_vld),
        .first_o (a_first),
        .neg_o   (a_neg),
        .big_o   (a_big),
        .mag_o   (a_mag)
    );

    xsop_accum #(
        .AL_W (AL_W),
        .ACC_W(ACC_W)
    ) u_acc (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .vld_i      (a_vld),
        .first_i    (a_first),
        .neg_i      (a_neg),
        .big_i      (a_big),
        .mag_i      (a_mag),
        .acc_o      (acc_o),
        .prod_big_o (prod_big_o),
        .acc_ovf_o  (acc_ovf_o),
        .vld_o      (out_valid_o)
    );

endmodule

// File: rtl/xprod_sop_chk.sv
module xprod_sop_chk #(
    parameter int EXP_W = 6,
    parameter int OP_W  = 14,
    parameter int ACC_W = 37
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic             in_valid_i,
    input logic             first_i,
    input logic [OP_W-1:0]  opa_i,
    input logic [OP_W-1:0]  opb_i,
    input logic [ACC_W-1:0] acc_o,
    input logic             prod_big_o,
    input logic             acc_ovf_o,
    input logic             out_valid_o
);

    logic [2:0] since_rst;
    logic       zero_a;

    assign zero_a = (opa_i[OP_W-2 -: EXP_W] == '0);

    always_ff @(posedge clk_i) begin
        if (rst_i)
            since_rst <= '0;
        else if (since_rst != 3'd7)
            since_rst <= since_rst + 3'd1;
    end

    // R2: result valid exactly four edges after the sampling edge
    assert_latency_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        (since_rst >= 3'd5) |-> (out_valid_o == $past(in_valid_i, 4)));

    // R3: zero-exponent operand leaves the sum and size flag untouched
    assert_zero_term_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        ((since_rst >= 3'd5) && out_valid_o && $past(in_valid_i && !first_i && zero_a, 4))
        |-> ((acc_o == $past(acc_o)) && (prod_big_o == $past(prod_big_o))));

    // R8: a zero product flagged as first clears the sum and both flags
    assert_restart_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        ((since_rst >= 3'd5) && out_valid_o && $past(in_valid_i && first_i && zero_a, 4))
        |-> ((acc_o == '0) && !prod_big_o && !acc_ovf_o));

    // R9: the accumulator only moves when a product arrives
    assert_idle_hold_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        !$stable(acc_o) |-> out_valid_o);

    // R6: the product-size flag only drops on an arriving product
    assert_big_sticky_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(prod_big_o) |-> out_valid_o);

    // R7: the overflow flag only drops on an arriving product
    assert_ovf_sticky_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(acc_ovf_o) |-> out_valid_o);

    // R10: first cycle after reset shows the cleared state
    assert_reset_state_R10: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(rst_i) |-> ((acc_o == '0) && !prod_big_o && !acc_ovf_o && !out_valid_o));

endmodule

bind xprod_sop xprod_sop_chk #(
    .EXP_W(EXP_W),
    .OP_W (OP_W),
    .ACC_W(ACC_W)
) u_chk (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .in_valid_i (in_valid_i),
    .first_i    (first_i),
    .opa_i      (opa_i),
    .opb_i      (opb_i),
    .acc_o      (acc_o),
    .prod_big_o (prod_big_o),
    .acc_ovf_o  (acc_ovf_o),
    .out_valid_o(out_valid_o)
);

// File: tb/sim_xprod_sop.sv
`timescale 1ns/1ps
module sim_xprod_sop;

    localparam int EXP_W   = 6;
    localparam int FRAC_W  = 7;
    localparam int ACC_LSB = -16;
    localparam int ACC_MSB = 20;
    localparam int PMAX    = 12;
    localparam int OP_W    = 1 + EXP_W + FRAC_W;
    localparam int ACC_W   = ACC_MSB - ACC_LSB + 1;
    localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
    localparam int LAT     = 4;

    logic             clk = 1'b0;
    logic             rst;
    logic             in_valid, first;
    logic [OP_W-1:0]  opa, opb;
    logic [ACC_W-1:0] acc;
    logic             pbig, aovf, ovalid;

    always #5 clk = ~clk;

    xprod_sop u0 (
        .clk_i(clk), .rst_i(rst), .in_valid_i(in_valid), .first_i(first),
        .opa_i(opa), .opb_i(opb), .acc_o(acc), .prod_big_o(pbig),
        .acc_ovf_o(aovf), .out_valid_o(ovalid)
    );

    int  n_tests = 0;
    int  n_fail  = 0;
    int  cyc     = 0;
    bit  mon_on  = 0;
    bit  done    = 0;

    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int     due;
        longint acc;
        bit     pb;
        bit     ao;
        int     tag;
    } exp_t;

    exp_t   pend[$];
    longint m_acc = 0;
    bit     m_pb  = 0;
    bit     m_ao  = 0;
    longint shown_acc = 0;
    bit     shown_pb  = 0;
    bit     shown_ao  = 0;

    function automatic string tag_name(input int k);
        case (k)
            1: return "R1";
            2: return "R2";
            3: return "R3";
            4: return "R4";
            5: return "R5";
            6: return "R6";
            7: return "R7";
            8: return "R8";
            9: return "R9";
            default: return "R10";
        endcase
    endfunction

    function automatic longint wrap_acc(input longint v);
        longint m;
        m = v & ((64'sd1 <<< ACC_W) - 1);
        if (m[ACC_W-1])
            m = m - (64'sd1 <<< ACC_W);
        return m;
    endfunction

    function automatic longint as_signed(input logic [ACC_W-1:0] v);
        return wrap_acc(longint'(v));
    endfunction

    // Exact product placed at ACC_LSB resolution (R1, R3, R4, R5, R6)
    function automatic void prod_model(input logic [OP_W-1:0] a, input logic [OP_W-1:0] b,
                                       output longint val, output bit big);
        int     ea, eb, e, off;
        longint p, mag;
        ea  = int'(a[OP_W-2 -: EXP_W]);
        eb  = int'(b[OP_W-2 -: EXP_W]);
        val = 0;
        big = 0;
        if (ea == 0 || eb == 0)
            return;
        e = ea + eb - 2 * BIAS;
        if (e + 1 > PMAX) begin
            big = 1;
            return;
        end
        p   = longint'({1'b1, a[FRAC_W-1:0]}) * longint'({1'b1, b[FRAC_W-1:0]});
        off = e - 2 * FRAC_W - ACC_LSB;
        if (off >= 0)
            mag = p <<< off;
        else if (-off >= 62)
            mag = 0;
        else
            mag = p >>> (-off);
        val = (a[OP_W-1] ^ b[OP_W-1]) ? -mag : mag;
    endfunction

    function automatic logic [OP_W-1:0] mk(input bit s, input int ef, input int fr);
        return {s, EXP_W'(ef), FRAC_W'(fr)};
    endfunction

    task automatic check(input bit ok, input int tag, input string what,
                         input longint got, input longint want);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", tag_name(tag), what, got, want);
        end
    endtask

    task automatic send(input logic [OP_W-1:0] a, input logic [OP_W-1:0] b,
                        input bit f, input int tag);
        longint v, s;
        bit     bg, ov;
        exp_t   ent;
        prod_model(a, b, v, bg);
        if (f) begin
            m_acc = v;
            m_pb  = bg;
            m_ao  = 0;
        end else begin
            s     = m_acc + v;
            ov    = (s > ((64'sd1 <<< (ACC_W - 1)) - 1)) || (s < -(64'sd1 <<< (ACC_W - 1)));
            m_acc = wrap_acc(s);
            m_pb  = m_pb | bg;
            m_ao  = m_ao | ov;
        end
        ent.due = cyc + LAT;
        ent.acc = m_acc;
        ent.pb  = m_pb;
        ent.ao  = m_ao;
        ent.tag = tag;
        pend.push_back(ent);
        in_valid = 1'b1;
        first    = f;
        opa      = a;
        opb      = b;
        @(negedge clk);
        in_valid = 1'b0;
        first    = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            in_valid = 1'b0;
            first    = $urandom_range(1, 0);
            opa      = OP_W'($urandom);
            opb      = OP_W'($urandom);
            @(negedge clk);
        end
        first = 1'b0;
    endtask

    // Result monitor: due cycles (R2) and quiet cycles (R9)
    always @(negedge clk) begin
        if (mon_on && !rst) begin
            if (pend.size() != 0 && pend[0].due == cyc) begin
                check(ovalid == 1'b1, 2, "out_valid at due cycle", longint'(ovalid), 1);
                check(as_signed(acc) == pend[0].acc, pend[0].tag, "acc value",
                      as_signed(acc), pend[0].acc);
                check(pbig == pend[0].pb, pend[0].tag, "prod_big flag",
                      longint'(pbig), longint'(pend[0].pb));
                check(aovf == pend[0].ao, pend[0].tag, "acc_ovf flag",
                      longint'(aovf), longint'(pend[0].ao));
                shown_acc = pend[0].acc;
                shown_pb  = pend[0].pb;
                shown_ao  = pend[0].ao;
                void'(pend.pop_front());
            end else begin
                check(ovalid == 1'b0, 9, "out_valid on quiet cycle", longint'(ovalid), 0);
                check(as_signed(acc) == shown_acc && pbig == shown_pb && aovf == shown_ao,
                      9, "state held on quiet cycle", as_signed(acc), shown_acc);
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int     dummy;
        logic [OP_W-1:0] ra, rb;
        dummy    = $urandom(32'h5EED);
        rst      = 1'b1;
        in_valid = 1'b0;
        first    = 1'b0;
        opa      = '0;
        opb      = '0;
        repeat (3) @(negedge clk);
        // R10: reset state
        check(acc == '0 && !pbig && !aovf && !ovalid, 10, "state in reset",
              as_signed(acc), 0);
        rst = 1'b0;
        @(negedge clk);
        check(acc == '0 && !pbig && !aovf && !ovalid, 10, "state after reset",
              as_signed(acc), 0);
        mon_on = 1;

        // R1: 1.0 * 1.0 loads 2^16 units
        send(mk(0, BIAS, 0), mk(0, BIAS, 0), 1, 1);
        // R5: 1.5 * -2.0 subtracts 3.0
        send(mk(0, BIAS, 64), mk(1, BIAS + 1, 0), 0, 5);
        // R3: zero exponent field against a huge operand
        send(mk(0, 0, 5), mk(0, 62, 127), 0, 3);
        idle(2);
        // R4: product with bits under the LSB, both signs
        send(mk(0, BIAS - 5, 1), mk(0, BIAS - 5, 127), 0, 4);
        send(mk(1, BIAS - 5, 1), mk(0, BIAS - 5, 127), 0, 4);
        send(mk(0, BIAS - 20, 127), mk(0, BIAS, 127), 0, 4);
        // R6: largest allowed product, then one just above the limit
        send(mk(0, BIAS + 6, 127), mk(0, BIAS + 5, 127), 0, 6);
        send(mk(0, BIAS + 6, 0), mk(0, BIAS + 6, 0), 0, 6);
        send(mk(0, BIAS, 0), mk(0, BIAS, 0), 0, 6);
        idle(3);
        // R8: restart with a zero product clears sum and flags
        send(mk(0, 0, 0), mk(0, BIAS, 3), 1, 8);
        // R7: drive the sum past the positive limit with back-to-back terms
        for (int i = 0; i < 140; i++)
            send(mk(0, BIAS + 6, 127), mk(0, BIAS + 5, 127), 0, 7);
        idle(2);
        // R8: restart with an oversize product
        send(mk(1, BIAS + 9, 3), mk(0, BIAS + 9, 3), 1, 8);
        send(mk(0, BIAS - 1, 9), mk(0, BIAS + 2, 33), 1, 8);
        // R7: negative overflow
        for (int i = 0; i < 140; i++)
            send(mk(1, BIAS + 6, 127), mk(0, BIAS + 5, 127), 0, 7);
        send(mk(0, BIAS, 0), mk(0, BIAS, 0), 1, 8);

        // random products mixed with gaps and restarts
        for (int i = 0; i < 600; i++) begin
            ra = mk($urandom_range(1, 0), ($urandom_range(15, 0) == 0) ? 0 : $urandom_range(42, 20),
                    $urandom_range(127, 0));
            rb = mk($urandom_range(1, 0), $urandom_range(42, 20), $urandom_range(127, 0));
            send(ra, rb, $urandom_range(31, 0) == 0, 1);
            if ($urandom_range(3, 0) == 0)
                idle($urandom_range(3, 1));
        end

        idle(LAT + 4);
        check(pend.size() == 0, 2, "all products delivered", longint'(pend.size()), 0);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule